// File: doc/BRIEF.md
# Strobe-Timed Bus Slave with Vectored Interrupt Acknowledge

This block is the bus-facing front end of a peripheral that sits on a microprocessor bus. That bus multiplexes its cycles with two strobes: an address strobe and a data strobe. The strobes are brought into the system clock through two-flop synchronizers. On the trailing (rising) edge of the address strobe, the block captures the register address, the first select line and the acknowledge flag. During the following data-strobe pulse it performs either a register read or a register write.

The block also answers interrupt acknowledge cycles. It keeps a small set of interrupt sources, each with a pending latch and an in-service latch, and takes part in a priority daisy chain through an enable-in and an enable-out line. When an acknowledge cycle is flagged at the address-strobe edge, the address, both selects and the direction line are disregarded. If the enable-in line is high and an eligible source is pending when the data strobe falls, the block takes the acknowledge. It then marks the winning source in service and drives an interrupt vector onto the data bus.

Top module: `strobe_bus_slave`

## Requirements
- R1: When the synchronized address strobe rises, the block captures `addr_in`, `sel_a` and `ack_n`. These inputs must stay stable for 3 clocks after the strobe rises. Later changes to them have no effect until the next address strobe.
- R2: A cycle is a read if `rd_wr` is 1 when the data strobe falls, and a write otherwise. A write takes effect when the data strobe rises. It takes effect only if the captured `sel_a` was 1, the captured `ack_n` was 1, and `sel_b` was 1 when the data strobe fell.
- R3: `data_oe` is 1 only while the synchronized data strobe is low. It is 1 for a read with captured `sel_a` = 1 and live `sel_b` = 1, or for an acknowledge cycle that this block has taken. It is 0 otherwise.
- R4: In a cycle whose captured `ack_n` was 0, the values of `addr_in`, `sel_a`, `sel_b` and `rd_wr` have no effect, and no register is written.
- R5: An acknowledge cycle is taken only if `ie_in` is 1 and at least one eligible source exists when the data strobe falls. An eligible source is one that is pending, enabled and not blocked by an in-service source of equal or higher priority. An acknowledge cycle that is not taken changes no state and leaves `data_oe` at 0.
- R6: A taken acknowledge selects the eligible source with the lowest index (index 0 is the highest priority). It clears that source's pending bit and sets its in-service bit. It drives the vector {base[7:2], index} for the rest of the data strobe.
- R7: `ie_out` is 0 whenever `ie_in` is 0, any in-service bit is set, or an acknowledge cycle is in progress while any enabled source is pending. Otherwise `ie_out` equals `ie_in`.
- R8: `irq` is 1 exactly when `ie_in` is 1 and at least one eligible source exists.
- R9: The register map is at addresses 0 to 3; addresses with any of bits 7:2 set read 0 and ignore writes. Address 0 holds the vector base (read/write). Address 1 holds the enable mask, whose bit i enables source i (read/write). Address 2 returns the pending bits, and a write of 1 to bit i clears pending bit i. Address 3 returns the in-service bits, and any write to it clears the lowest-index in-service bit that is set.
- R10: A one-cycle pulse on `src_req[i]` sets pending bit i. After reset all registers read 0, `data_oe` and `irq` are 0, and `ie_out` follows `ie_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Address strobe, active low; its rising edge captures the address phase |
| ds_n | input | 1 | Data strobe, active low |
| addr_in | input | 8 | Register address |
| sel_a | input | 1 | First select, captured on the address strobe |
| sel_b | input | 1 | Second select, used during the data strobe |
| rd_wr | input | 1 | 1 = read, 0 = write |
| ack_n | input | 1 | Interrupt acknowledge flag, active low |
| ie_in | input | 1 | Daisy-chain enable in |
| src_req | input | 4 | Per-source interrupt request pulses |
| data_in | input | 8 | Write data |
| data_out | output | 8 | Read data or interrupt vector |
| data_oe | output | 1 | Data bus driver enable |
| ie_out | output | 1 | Daisy-chain enable out |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is nested service: a lower-priority source must become pending while a higher one is already in service, stay masked from `irq`, and then surface only after in-service bits are cleared one at a time through address 3. The stimulus builds this up step by step. It raises source 2 and acknowledges it, then raises sources 3 and 0 and acknowledges source 0. It then releases the in-service bits in priority order, checking the vector, `irq` and `ie_out` at every step. The acknowledge cycles also flip the captured lines right after capture and present a write-like address and data, so that any leak of those inputs into the register file would show up.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // Register selects inside the 4-word window (the low two address bits)
  typedef enum logic [1:0] {
    SEL_VBASE = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_PEND  = 2'd2,
    SEL_INSVC = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
  parameter int W        = 2,
  parameter bit RST_HIGH = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  localparam logic [W-1:0] RV = RST_HIGH ? '1 : '0;
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RV;
      s2 <= RV;
      s3 <= RV;
    end else begin
      s1 <= d;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign q    = s2;
  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
endmodule

// File: rtl/sbs_regs.sv
module sbs_regs #(
  parameter int N_SRC = 4,
  parameter int DW    = 8,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             wr_commit,
  input  logic [DW-1:0]    wdata,
  input  logic [N_SRC-1:0] src_req,
  input  logic             ack_take,
  input  logic             ack_cyc,
  input  logic             ie_in,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    vec_q,
  output logic [N_SRC-1:0] ius_q,
  output logic             any_elig,
  output logic             ie_out,
  output logic             irq
);
  import sbs_pkg::*;
  localparam int IDXW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [DW-1:0]    base_q, mask_q;
  logic [N_SRC-1:0] pend_q, pend_n, ius_n, blocked, elig, pend_en;
  logic [IDXW-1:0]  win_idx;
  logic             in_win;
  reg_sel_e         sel;

  // index of the lowest set bit (highest priority)
  function automatic logic [IDXW-1:0] first_set(input logic [N_SRC-1:0] v);
    first_set = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (v[i]) first_set = IDXW'(i);
  endfunction

  // bit i is set when any in-service bit at index <= i is set
  function automatic logic [N_SRC-1:0] block_mask(input logic [N_SRC-1:0] s);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      acc = acc | s[i];
      block_mask[i] = acc;
    end
  endfunction

  assign in_win   = (reg_addr[AW-1:2] == '0);
  assign sel      = reg_sel_e'(reg_addr[1:0]);
  assign pend_en  = pend_q & mask_q[N_SRC-1:0];
  assign blocked  = block_mask(ius_q);
  assign elig     = pend_en & ~blocked;
  assign any_elig = |elig;
  assign win_idx  = first_set(elig);

  always_comb begin
    pend_n = pend_q;
    ius_n  = ius_q;
    if (wr_commit && in_win && sel == SEL_PEND)
      pend_n = pend_n & ~wdata[N_SRC-1:0];
    if (wr_commit && in_win && sel == SEL_INSVC && (|ius_q))
      ius_n[first_set(ius_q)] = 1'b0;
    if (ack_take) begin
      pend_n[win_idx] = 1'b0;
      ius_n[win_idx]  = 1'b1;
    end
    pend_n = pend_n | src_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      pend_q <= '0;
      ius_q  <= '0;
      vec_q  <= '0;
    end else begin
      pend_q <= pend_n;
      ius_q  <= ius_n;
      if (wr_commit && in_win && sel == SEL_VBASE) base_q <= wdata;
      if (wr_commit && in_win && sel == SEL_MASK)  mask_q <= wdata;
      if (ack_take) vec_q <= {base_q[DW-1:IDXW], win_idx};
    end
  end

  always_comb begin
    rd_data = '0;
    if (in_win) begin
      unique case (sel)
        SEL_VBASE: rd_data = base_q;
        SEL_MASK:  rd_data = mask_q;
        SEL_PEND:  rd_data = {{(DW-N_SRC){1'b0}}, pend_q};
        SEL_INSVC: rd_data = {{(DW-N_SRC){1'b0}}, ius_q};
      endcase
    end
  end

  assign ie_out = ie_in & ~(|ius_q) & ~(ack_cyc & (|pend_en));
  assign irq    = ie_in & any_elig;
endmodule

// File: rtl/strobe_bus_slave.sv
module strobe_bus_slave #(
  parameter int N_SRC = 4,
  parameter int DW    = 8,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             as_n,
  input  logic             ds_n,
  input  logic [AW-1:0]    addr_in,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             rd_wr,
  input  logic             ack_n,
  input  logic             ie_in,
  input  logic [N_SRC-1:0] src_req,
  input  logic [DW-1:0]    data_in,
  output logic [DW-1:0]    data_out,
  output logic             data_oe,
  output logic             ie_out,
  output logic             irq
);
  logic [1:0] st_q, st_rise, st_fall;
  logic       as_rise, ds_fall, ds_rise, ds_active;
  logic [AW-1:0] lat_addr;
  logic       lat_sel, ack_cyc, acc_ok, rd_lat, own_q;
  logic       ack_take, wr_commit, any_elig;
  logic [DW-1:0] rd_data, vec_q;
  logic [N_SRC-1:0] ius_q;

  sbs_sync #(.W(2), .RST_HIGH(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ds_n, as_n}),
    .q(st_q), .rise(st_rise), .fall(st_fall)
  );

  assign as_rise   = st_rise[0];
  assign ds_fall   = st_fall[1];
  assign ds_rise   = st_rise[1];
  assign ds_active = ~st_q[1];

  assign ack_take  = ds_fall & ack_cyc & ie_in & any_elig;
  assign wr_commit = ds_rise & acc_ok & ~rd_lat & ~ack_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0;
      lat_sel  <= 1'b0;
      ack_cyc  <= 1'b0;
      acc_ok   <= 1'b0;
      rd_lat   <= 1'b0;
      own_q    <= 1'b0;
    end else if (as_rise) begin
      lat_addr <= addr_in;
      lat_sel  <= sel_a;
      ack_cyc  <= ~ack_n;
      acc_ok   <= 1'b0;
      own_q    <= 1'b0;
    end else if (ds_fall) begin
      rd_lat <= rd_wr;
      acc_ok <= ~ack_cyc & lat_sel & sel_b;
      own_q  <= ack_take;
    end else if (ds_rise) begin
      acc_ok  <= 1'b0;
      own_q   <= 1'b0;
      ack_cyc <= 1'b0;
    end
  end

  sbs_regs #(.N_SRC(N_SRC), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(lat_addr), .wr_commit(wr_commit),
    .wdata(data_in), .src_req(src_req), .ack_take(ack_take), .ack_cyc(ack_cyc),
    .ie_in(ie_in), .rd_data(rd_data), .vec_q(vec_q), .ius_q(ius_q),
    .any_elig(any_elig), .ie_out(ie_out), .irq(irq)
  );

  assign data_oe  = ds_active & ((acc_ok & rd_lat & sel_b) | own_q);
  assign data_out = own_q ? vec_q : rd_data;
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int N_SRC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ds_active,
  input logic             data_oe,
  input logic             ie_in,
  input logic             ie_out,
  input logic             irq,
  input logic             ack_take,
  input logic             ack_cyc,
  input logic             wr_commit,
  input logic [N_SRC-1:0] ius_q
);
  assert_oe_only_in_ds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> ds_active);

  assert_ieo_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_in |-> !ie_out);

  assert_take_needs_iei_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |-> ie_in);

  assert_take_adds_ius_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> ($countones(ius_q) == $countones($past(ius_q)) + 1));

  assert_no_write_in_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !ack_cyc);

  assert_irq_needs_iei_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie_in);
endmodule

bind strobe_bus_slave sbs_checker #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ds_active(ds_active), .data_oe(data_oe),
  .ie_in(ie_in), .ie_out(ie_out), .irq(irq), .ack_take(ack_take),
  .ack_cyc(ack_cyc), .wr_commit(wr_commit), .ius_q(ius_q)
);

// File: tb/sim_strobe_bus_slave.sv
module sim_strobe_bus_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic as_n = 1'b1, ds_n = 1'b1, sel_a = 1'b0, sel_b = 1'b0, rd_wr = 1'b1;
  logic ack_n = 1'b1, ie_in = 1'b1;
  logic [7:0] addr_in = '0, data_in = '0;
  logic [3:0] src_req = '0;
  logic [7:0] data_out;
  logic data_oe, ie_out, irq;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // behavioural reference state
  logic [7:0] m_base = '0, m_mask = '0;
  logic [3:0] m_pend = '0, m_ius = '0;

  always #4 clk = ~clk; // 125 MHz

  strobe_bus_slave u0 (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .addr_in(addr_in),
    .sel_a(sel_a), .sel_b(sel_b), .rd_wr(rd_wr), .ack_n(ack_n), .ie_in(ie_in),
    .src_req(src_req), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .ie_out(ie_out), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] m_elig();
    logic [3:0] e;
    logic blk;
    blk = 1'b0;
    for (int i = 0; i < 4; i++) begin
      blk = blk | m_ius[i];
      e[i] = m_pend[i] & m_mask[i] & ~blk;
    end
    return e;
  endfunction

  function automatic int m_first(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return 0;
  endfunction

  // idle-state comparison against the model (R7, R8)
  task automatic check_idle();
    logic exp_irq, exp_ieo;
    exp_irq = ie_in & (|m_elig());
    exp_ieo = ie_in & ~(|m_ius);
    check(irq == exp_irq, "R8 irq", irq, exp_irq);
    check(ie_out == exp_ieo, "R7 ie_out idle", ie_out, exp_ieo);
    check(data_oe == 1'b0, "R3 oe idle", data_oe, 0);
  endtask

  // one strobe cycle; captured lines are flipped right after capture (R1)
  task automatic bus_cycle(input logic [7:0] a, input logic sa, input logic sb,
                           input logic rw, input logic ackn, input logic [7:0] wd,
                           output logic [7:0] rd, output logic oe, output logic ieo);
    @(negedge clk);
    addr_in = a; sel_a = sa; ack_n = ackn; as_n = 1'b0;
    repeat (2) @(negedge clk);
    as_n = 1'b1;
    repeat (4) @(negedge clk);
    addr_in = a ^ 8'h01; sel_a = ~sa; ack_n = ~ackn;
    rd_wr = rw; sel_b = sb; data_in = wd;
    repeat (2) @(negedge clk);
    ds_n = 1'b0;
    repeat (5) @(negedge clk);
    rd = data_out; oe = data_oe; ieo = ie_out;
    ds_n = 1'b1;
    repeat (5) @(negedge clk);
    sel_b = 1'b0; ack_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r; logic oe, ieo;
    bus_cycle(a, 1'b1, 1'b1, 1'b0, 1'b1, d, r, oe, ieo);
    check(oe == 1'b0, "R3 no oe on write", oe, 0);
    if (a[7:2] == 0) begin
      case (a[1:0])
        2'd0: m_base = d;
        2'd1: m_mask = d;
        2'd2: m_pend = m_pend & ~d[3:0];
        default: if (|m_ius) m_ius[m_first(m_ius)] = 1'b0;
      endcase
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input string req);
    logic [7:0] r, e; logic oe, ieo;
    bus_cycle(a, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, r, oe, ieo);
    e = 8'h00;
    if (a[7:2] == 0)
      case (a[1:0])
        2'd0: e = m_base;
        2'd1: e = m_mask;
        2'd2: e = {4'h0, m_pend};
        default: e = {4'h0, m_ius};
      endcase
    check(oe == 1'b1, {req, " oe"}, oe, 1);
    check(r == e, req, r, e);
  endtask

  task automatic raise(input int i);
    @(negedge clk); src_req[i] = 1'b1;
    @(negedge clk); src_req = '0;
    @(negedge clk);
    m_pend[i] = 1'b1;
  endtask

  // acknowledge cycle with write-like inputs that must be ignored (R4)
  task automatic ack_cycle(input string req);
    logic [7:0] r, ev; logic oe, ieo, own; logic [3:0] e; int idx;
    e = m_elig();
    own = ie_in & (|e);
    idx = m_first(e);
    bus_cycle(8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h55, r, oe, ieo);
    check(oe == own, {req, " R5 oe"}, oe, own);
    check(ieo == 1'b0, {req, " R7 ie_out in ack"}, ieo, 0);
    if (own) begin
      ev = {m_base[7:2], 2'(idx)};
      check(r == ev, {req, " R6 vector"}, r, ev);
      m_pend[idx] = 1'b0;
      m_ius[idx]  = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10 reset state
    check(data_oe == 0 && irq == 0, "R10 reset outputs", {data_oe, irq}, 0);
    check(ie_out == 1'b1, "R10 ie_out follows ie_in", ie_out, 1);
    rd_chk(8'h00, "R10 base after reset");
    rd_chk(8'h03, "R10 insvc after reset");
    // R2/R9/R1 writes and readback; address flips to reg1 after capture
    wr(8'h00, 8'hA4);
    wr(8'h01, 8'h0F);
    rd_chk(8'h00, "R1 R9 base readback");
    rd_chk(8'h01, "R9 mask readback");
    // R9 outside the window
    wr(8'h44, 8'h11);
    rd_chk(8'h44, "R9 out-of-window reads 0");
    rd_chk(8'h00, "R9 base unchanged by out-of-window write");
    // R2 write with sel_b low, and with sel_a low, is ignored
    begin
      logic [7:0] r; logic oe, ieo;
      bus_cycle(8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h33, r, oe, ieo);
      bus_cycle(8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h66, r, oe, ieo);
      check(oe == 1'b0, "R2 oe with sel_a low", oe, 0);
      // R3 read with sel_b low keeps drivers off
      bus_cycle(8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, r, oe, ieo);
      check(oe == 1'b0, "R3 read with sel_b low", oe, 0);
    end
    rd_chk(8'h00, "R2 base unchanged by deselected writes");
    check_idle();
    // R10 R8 request source 2
    raise(2);
    check_idle();
    rd_chk(8'h02, "R10 pending after request");
    // R5 ie_in low: acknowledge not taken
    ie_in = 1'b0;
    @(negedge clk);
    check(ie_out == 1'b0, "R7 ie_out with ie_in low", ie_out, 0);
    check_idle();
    ack_cycle("iei-low");
    ie_in = 1'b1;
    rd_chk(8'h02, "R5 pending kept after untaken ack");
    rd_chk(8'h03, "R5 insvc kept after untaken ack");
    // R6 taken acknowledge for source 2
    ack_cycle("src2");
    rd_chk(8'h00, "R4 base unchanged by ack cycle");
    rd_chk(8'h03, "R6 insvc after ack");
    rd_chk(8'h02, "R6 pending cleared by ack");
    check_idle();
    // R8 nesting: source 3 blocked, source 0 preempts
    raise(3);
    check_idle();
    raise(0);
    check_idle();
    ack_cycle("src0");
    rd_chk(8'h03, "R6 nested insvc");
    check_idle();
    // R9 clear highest in-service, one at a time
    wr(8'h03, 8'h00);
    rd_chk(8'h03, "R9 first insvc clear");
    check_idle();
    wr(8'h03, 8'h00);
    rd_chk(8'h03, "R9 second insvc clear");
    check_idle();
    ack_cycle("src3");
    wr(8'h03, 8'h00);
    // R9 write-1-to-clear pending
    raise(1);
    raise(3);
    wr(8'h02, 8'h02);
    rd_chk(8'h02, "R9 pending w1c");
    check_idle();
    // R8 mask disables request
    wr(8'h01, 8'h00);
    check_idle();
    rd_chk(8'h02, "R8 pending kept while masked");
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule